// File: doc/BRIEF.md
# Ethernet Receive Frame Statistics Counters

This block keeps receive statistics for a three-port Ethernet MAC. Each port reports the end of every received frame as a one-cycle event. The event carries the frame's byte count and four flags: VLAN tag present, bad FCS, symbol error, and a trailing extra nibble (dribble). The block sorts each frame against a legal length window and the error flags. It then adds one to either that port's good-frame counter or its CRC-error counter, or to neither.

Software reads the counters through a small read port: a one-cycle strobe with an address, and the data one clock later. A read returns the counter and clears it. Counters stop at their all-ones value instead of wrapping. Each port has its own static configuration bit that widens the length window for 2K jumbo frames.

Top module: `rx_frame_stats`

## Requirements
- R1: After a synchronous active-low reset, every counter reads as zero.
- R2: A port's good-frame counter increments by one for each frame whose length lies inside the legal window and that has neither a bad FCS nor a symbol error. The dribble flag does not affect this counter.
- R3: A port's CRC-error counter increments by one for each frame whose length lies inside the legal window, that has a bad FCS, and that has neither a symbol error nor a dribble nibble.
- R4: With the jumbo bit clear, the legal window is 64 to 1518 bytes for untagged frames and 64 to 1522 bytes for tagged frames, both ends inclusive.
- R5: With a port's jumbo bit set, that port's legal window is 64 to 2048 bytes, whether the frame is tagged or not.
- R6: A frame shorter than 64 bytes or longer than the window maximum changes neither counter.
- R7: A counter that holds all-ones (FFFF_FFFFh at the default 32-bit width) keeps that value on further qualifying frames.
- R8: A read returns the counter's current value and leaves the counter at zero.
- R9: If a read of a counter and a qualifying frame for that counter fall in the same cycle, the read returns the old value and the counter is left at 1.
- R10: A read of an address that maps to no counter returns zero and changes no counter.
- R11: A frame with a symbol error increments neither counter, even when its FCS is also bad.
- R12: Port p (0, 1, 2) has its good-frame counter at address (p+1)*400h + 18h and its CRC-error counter at (p+1)*400h + 19h. Read data appears on the clock after the strobe and is zero in every cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_end | input | 3 | Per-port end-of-frame event, one cycle per frame |
| frm_len | input | 36 | Per-port frame byte length, 12 bits per port, port 0 in the low bits |
| frm_tagged | input | 3 | Per-port VLAN-tag flag |
| frm_fcs_bad | input | 3 | Per-port bad-FCS flag |
| frm_sym_bad | input | 3 | Per-port symbol-error flag |
| frm_dribble | input | 3 | Per-port extra-nibble flag |
| jumbo_en | input | 3 | Per-port 2K jumbo window enable |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | 12 | Read address |
| rd_data | output | 32 | Read data, valid the clock after the strobe |

## Verification
The assertions assume that each port's length and flag inputs are meaningful only in a cycle where that port's frame-end bit is high. They also assume the jumbo bits change only between frames, and that the read address is looked at only together with the strobe. The stimulus holds every flag and length at zero outside its event cycle and changes the jumbo bits only on idle cycles. A behavioural model compares read data with its own result on every clock. A narrow counter width makes the saturation point reachable within a short run.

// File: rtl/rxfs_pkg.sv
// Package rxfs_pkg
// Shared constants for the receive frame statistics block: the frame
// length window limits and the register address layout.
// Assumes: lengths are plain byte counts, addresses are word numbers.
package rxfs_pkg;
    localparam int unsigned MIN_FRAME_LEN   = 64;
    localparam int unsigned MAX_UNTAGGED    = 1518;
    localparam int unsigned MAX_TAGGED      = 1522;
    localparam int unsigned MAX_JUMBO       = 2048;

    localparam int unsigned PORT_STRIDE     = 1024;
    localparam int unsigned GOOD_OFS        = 'h18;
    localparam int unsigned CRCERR_OFS      = 'h19;

    // Which counter a frame should bump, if any.
    typedef struct packed {
        logic good;
        logic crc;
    } frame_verdict_t;
endpackage

// File: rtl/rxfs_classify.sv
// Module rxfs_classify
// Sorts one port's end-of-frame event into good frame, CRC-error frame or
// neither. The decision is purely combinational.
// Assumes: length and flags are meaningful only while frm_end is high.
module rxfs_classify
    import rxfs_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_tagged,
    input  logic             frm_fcs_bad,
    input  logic             frm_sym_bad,
    input  logic             frm_dribble,
    input  logic             jumbo_en,
    output frame_verdict_t   verdict
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_FRAME_LEN);
    localparam logic [LEN_W-1:0] LEN_UNT = LEN_W'(MAX_UNTAGGED);
    localparam logic [LEN_W-1:0] LEN_TAG = LEN_W'(MAX_TAGGED);
    localparam logic [LEN_W-1:0] LEN_JMB = LEN_W'(MAX_JUMBO);

    logic [LEN_W-1:0] len_max;
    logic             len_ok;

    // Choose the upper length limit from the jumbo bit and the tag flag.
    always_comb begin
        if (jumbo_en)        len_max = LEN_JMB;
        else if (frm_tagged) len_max = LEN_TAG;
        else                 len_max = LEN_UNT;
    end

    // Length window check, both ends inclusive.
    always_comb len_ok = (frm_len >= LEN_MIN) && (frm_len <= len_max);

    // Final verdict: a symbol error excludes the frame from both counts.
    always_comb begin
        verdict.good = frm_end && len_ok && !frm_fcs_bad && !frm_sym_bad;
        verdict.crc  = frm_end && len_ok &&  frm_fcs_bad && !frm_sym_bad
                       && !frm_dribble;
    end
endmodule

// File: rtl/rxfs_sat_counter.sv
// Module rxfs_sat_counter
// Saturating event counter with clear-on-read. When clear and increment
// coincide, the counter restarts at one so the event is kept.
// Assumes: clr is a single-cycle pulse issued with the read that returns
// the current value.
module rxfs_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Count update with clear priority and saturation at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= inc ? CNT_ONE : '0;
        else if (inc && (cnt != CNT_MAX))
            cnt <= cnt + CNT_ONE;
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R8
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt == '0));

    // R9
    clear_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt == CNT_ONE));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/rxfs_read_port.sv
// Module rxfs_read_port
// Decodes the read address against every counter and registers the
// selected value. It also issues the per-counter clear pulses.
// Assumes: the address matters only while rd_stb is high.
module rxfs_read_port
    import rxfs_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_stb,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [CNT_W-1:0]     good_cnt [NUM_PORTS],
    input  logic [CNT_W-1:0]     crc_cnt  [NUM_PORTS],
    output logic [NUM_PORTS-1:0] good_clr,
    output logic [NUM_PORTS-1:0] crc_clr,
    output logic [CNT_W-1:0]     rd_data
);
    logic [NUM_PORTS-1:0] good_hit;
    logic [NUM_PORTS-1:0] crc_hit;
    logic [CNT_W-1:0]     sel_val;

    // One address comparator per counter.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_GOOD = ADDR_W'((p + 1) * PORT_STRIDE + GOOD_OFS);
        localparam logic [ADDR_W-1:0] A_CRC  = ADDR_W'((p + 1) * PORT_STRIDE + CRCERR_OFS);
        assign good_hit[p] = rd_stb && (rd_addr == A_GOOD);
        assign crc_hit[p]  = rd_stb && (rd_addr == A_CRC);
    end

    assign good_clr = good_hit;
    assign crc_clr  = crc_hit;

    // OR-mux of the selected counter; at most one hit is ever set.
    always_comb begin
        sel_val = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (good_hit[p]) sel_val |= good_cnt[p];
            if (crc_hit[p])  sel_val |= crc_cnt[p];
        end
    end

    // Register read data; zero when no strobe or unmapped address.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= sel_val;
    end

    // R12
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({good_hit, crc_hit}));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (rd_data == '0));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(|{good_hit, crc_hit})) |=> (rd_data == '0));
endmodule

// File: rtl/rx_frame_stats.sv
// Module rx_frame_stats
// Top level of the per-port receive statistics block: a frame classifier
// and two saturating clear-on-read counters per port, plus a shared
// read port.
// Assumes: the jumbo bits change only between frames; each frame-end
// event lasts exactly one cycle.
module rx_frame_stats
    import rxfs_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int LEN_W     = 12,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       frm_end,
    input  logic [NUM_PORTS*LEN_W-1:0] frm_len,
    input  logic [NUM_PORTS-1:0]       frm_tagged,
    input  logic [NUM_PORTS-1:0]       frm_fcs_bad,
    input  logic [NUM_PORTS-1:0]       frm_sym_bad,
    input  logic [NUM_PORTS-1:0]       frm_dribble,
    input  logic [NUM_PORTS-1:0]       jumbo_en,
    input  logic                       rd_stb,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [CNT_W-1:0]           rd_data
);
    logic [CNT_W-1:0]     good_cnt [NUM_PORTS];
    logic [CNT_W-1:0]     crc_cnt  [NUM_PORTS];
    logic [NUM_PORTS-1:0] good_clr;
    logic [NUM_PORTS-1:0] crc_clr;
    frame_verdict_t       verdict  [NUM_PORTS];

    // Per-port classifier and counter pair.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rxfs_classify #(.LEN_W(LEN_W)) u_cls (
            .frm_end     (frm_end[p]),
            .frm_len     (frm_len[p*LEN_W +: LEN_W]),
            .frm_tagged  (frm_tagged[p]),
            .frm_fcs_bad (frm_fcs_bad[p]),
            .frm_sym_bad (frm_sym_bad[p]),
            .frm_dribble (frm_dribble[p]),
            .jumbo_en    (jumbo_en[p]),
            .verdict     (verdict[p])
        );

        rxfs_sat_counter #(.CNT_W(CNT_W)) u_good (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (verdict[p].good),
            .clr   (good_clr[p]),
            .cnt   (good_cnt[p])
        );

        rxfs_sat_counter #(.CNT_W(CNT_W)) u_crc (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (verdict[p].crc),
            .clr   (crc_clr[p]),
            .cnt   (crc_cnt[p])
        );

        // R11
        sym_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_end[p] && frm_sym_bad[p]) |-> !(verdict[p].good || verdict[p].crc));

        // R6
        no_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !frm_end[p] |-> !(verdict[p].good || verdict[p].crc));

        // R3
        disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({verdict[p].good, verdict[p].crc}));
    end

    // Shared read port and clear generation.
    rxfs_read_port #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .good_cnt (good_cnt),
        .crc_cnt  (crc_cnt),
        .good_clr (good_clr),
        .crc_clr  (crc_clr),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/test_rx_frame_stats.sv
module test_rx_frame_stats;
    localparam int NP    = 3;
    localparam int LW    = 12;
    localparam int CW    = 8;
    localparam int AW    = 12;
    localparam int CMAX  = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     frm_end = '0;
    logic [NP*LW-1:0]  frm_len = '0;
    logic [NP-1:0]     frm_tagged = '0;
    logic [NP-1:0]     frm_fcs_bad = '0;
    logic [NP-1:0]     frm_sym_bad = '0;
    logic [NP-1:0]     frm_dribble = '0;
    logic [NP-1:0]     jumbo_en = '0;
    logic              rd_stb = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [CW-1:0]     rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1 reset";

    int gm [NP];
    int cm [NP];
    int exp_rd = 0;

    rx_frame_stats #(.NUM_PORTS(NP), .LEN_W(LW), .CNT_W(CW), .ADDR_W(AW)) i_rx_frame_stats (
        .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_len(frm_len),
        .frm_tagged(frm_tagged), .frm_fcs_bad(frm_fcs_bad), .frm_sym_bad(frm_sym_bad),
        .frm_dribble(frm_dribble), .jumbo_en(jumbo_en), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic int good_addr(int p); return (p + 1) * 1024 + 24; endfunction
    function automatic int crc_addr(int p);  return (p + 1) * 1024 + 25; endfunction

    function automatic int win_max(bit jmb, bit tag);
        if (jmb) return 2048;
        return tag ? 1522 : 1518;
    endfunction

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin : model
        int sg;
        int sc;
        int len;
        bit inw;
        bit g;
        bit c;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin gm[p] = 0; cm[p] = 0; end
            exp_rd = 0;
        end else begin
            sg = -1; sc = -1; exp_rd = 0;
            if (rd_stb) begin
                for (int p = 0; p < NP; p++) begin
                    if (int'(rd_addr) == good_addr(p)) begin exp_rd = gm[p]; sg = p; end
                    if (int'(rd_addr) == crc_addr(p))  begin exp_rd = cm[p]; sc = p; end
                end
            end
            for (int p = 0; p < NP; p++) begin
                len = int'(frm_len[p*LW +: LW]);
                inw = (len >= 64) && (len <= win_max(jumbo_en[p], frm_tagged[p]));
                g = frm_end[p] && inw && !frm_fcs_bad[p] && !frm_sym_bad[p];
                c = frm_end[p] && inw && frm_fcs_bad[p] && !frm_sym_bad[p] && !frm_dribble[p];
                if (sg == p) gm[p] = g ? 1 : 0;
                else if (g && gm[p] < CMAX) gm[p]++;
                if (sc == p) cm[p] = c ? 1 : 0;
                else if (c && cm[p] < CMAX) cm[p]++;
            end
        end
    end

    // Compare read data with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(rd_data) !== exp_rd) begin
                errors++;
                $display("FAIL %s: rd_data actual %0d expected %0d", phase, rd_data, exp_rd);
            end
        end
    end

    task automatic frame(int p, int len, bit tag, bit fcs, bit sym, bit drb);
        @(negedge clk);
        frm_end[p] = 1'b1; frm_len[p*LW +: LW] = LW'(len);
        frm_tagged[p] = tag; frm_fcs_bad[p] = fcs; frm_sym_bad[p] = sym; frm_dribble[p] = drb;
        @(negedge clk);
        frm_end[p] = 1'b0; frm_len[p*LW +: LW] = '0;
        frm_tagged[p] = 1'b0; frm_fcs_bad[p] = 1'b0; frm_sym_bad[p] = 1'b0; frm_dribble[p] = 1'b0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        rd_stb = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_stb = 1'b0; rd_addr = '0;
    endtask

    // Direct check of one read against a value worked out by hand.
    task automatic rd_expect(int a, int v, string req);
        rd(a);
        checks++;
        if (int'(rd_data) !== v) begin
            errors++;
            $display("FAIL %s: read %0h actual %0d expected %0d", req, a, rd_data, v);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every counter reads zero after reset
        for (int p = 0; p < NP; p++) begin
            rd_expect(good_addr(p), 0, "R1");
            rd_expect(crc_addr(p), 0, "R1");
        end

        phase = "R2 R4 untagged/tagged window";
        frame(0, 64, 0, 0, 0, 0);
        frame(0, 1518, 0, 0, 0, 0);
        frame(0, 1519, 0, 0, 0, 0);
        frame(0, 1522, 1, 0, 0, 0);
        frame(0, 1523, 1, 0, 0, 0);
        frame(0, 700, 0, 0, 0, 1);
        rd_expect(good_addr(0), 4, "R2 R4");

        phase = "R3 crc window and dribble";
        frame(1, 64, 0, 1, 0, 0);
        frame(1, 1522, 1, 1, 0, 0);
        frame(1, 1518, 0, 1, 0, 1);
        frame(1, 1519, 0, 1, 0, 0);
        rd_expect(crc_addr(1), 2, "R3");
        rd_expect(good_addr(1), 0, "R3");

        phase = "R5 jumbo window";
        @(negedge clk); jumbo_en[2] = 1'b1;
        frame(2, 2048, 0, 0, 0, 0);
        frame(2, 2049, 1, 0, 0, 0);
        frame(2, 2000, 0, 1, 0, 0);
        rd_expect(good_addr(2), 1, "R5");
        rd_expect(crc_addr(2), 1, "R5");
        @(negedge clk); jumbo_en[2] = 1'b0;

        phase = "R6 out of window";
        frame(0, 63, 0, 0, 0, 0);
        frame(0, 0, 0, 1, 0, 0);
        frame(0, 4000, 1, 0, 0, 0);
        rd_expect(good_addr(0), 0, "R6");
        rd_expect(crc_addr(0), 0, "R6");

        phase = "R11 symbol error";
        frame(1, 500, 0, 1, 1, 0);
        frame(1, 500, 0, 0, 1, 0);
        rd_expect(good_addr(1), 0, "R11");
        rd_expect(crc_addr(1), 0, "R11");

        phase = "R7 saturation";
        for (int i = 0; i < CMAX + 5; i++) frame(0, 100, 0, 0, 0, 0);
        rd_expect(good_addr(0), CMAX, "R7");

        phase = "R8 clear on read";
        frame(2, 100, 0, 1, 0, 0);
        frame(2, 100, 0, 1, 0, 0);
        rd_expect(crc_addr(2), 2, "R8");
        rd_expect(crc_addr(2), 0, "R8");

        phase = "R9 read with event";
        frame(1, 300, 0, 0, 0, 0);
        frame(1, 300, 0, 0, 0, 0);
        @(negedge clk);
        rd_stb = 1'b1; rd_addr = AW'(good_addr(1));
        frm_end[1] = 1'b1; frm_len[1*LW +: LW] = LW'(300);
        @(negedge clk);
        rd_stb = 1'b0; rd_addr = '0; frm_end[1] = 1'b0; frm_len[1*LW +: LW] = '0;
        checks++;
        if (rd_data !== CW'(2)) begin
            errors++;
            $display("FAIL R9: actual %0d expected 2", rd_data);
        end
        rd_expect(good_addr(1), 1, "R9");

        phase = "R10 unmapped address";
        frame(0, 200, 0, 0, 0, 0);
        rd_expect('h418 + 2, 0, "R10");
        rd_expect('h018, 0, "R10");
        rd_expect('h1018, 0, "R10");
        rd_expect(good_addr(0), 1, "R10");

        phase = "R12 address map and idle zero";
        for (int p = 0; p < NP; p++) begin
            frame(p, 80 + p, 0, 0, 0, 0);
            frame(p, 90, 0, 1, 0, 0);
            frame(p, 90, 0, 1, 0, 0);
        end
        for (int p = 0; p < NP; p++) begin
            rd_expect(good_addr(p), 1, "R12");
            rd_expect(crc_addr(p), 2, "R12");
        end
        repeat (4) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule